// File: doc/BRIEF.md
# NAND Flash Device Emulator

This block is a synthesizable, scaled-down stand-in for a NAND flash part with an 8-bit multiplexed I/O bus. A host drives the pin-level strobes: chip enable, command latch, address latch, write enable and read enable, all active as on a real part. The emulator decodes command, address and data cycles from rising edges of the write strobe. It keeps a page register and a small array arranged as blocks of pages, and it carries out page read, page program and block erase. While an array operation runs, a ready/busy output stays low for a fixed number of clock cycles.

All pins are sampled on the emulator's own clock. The host must hold each strobe level for at least two clock cycles so that every edge is seen. The byte stream has no valid/ready handshake. The host paces transfers in both directions: each write-strobe rise accepts one byte, and each read-strobe rise moves the output to the next byte. The only back-pressure is the ready/busy pin, and the host must wait for it to go high before it starts the next array operation. The array is sized by parameters, and the page has a data part and a spare part. Busy times are counts of clock cycles, scaled from the nominal 25 us read, 300 us program and 2 ms erase.

Top module: `nand_emu`

## Requirements
- R1: While `ce_n` is high, the device ignores every strobe: no command, address or data cycle takes effect and `dq_oe` stays low.
- R2: A byte on `dq_in` is taken on the clock where a rising `we_n` is seen. It is a command when `cle`=1 and `ale`=0, an address when `ale`=1 and `cle`=0, and data when both are 0. Command codes are 00h/30h for read, 80h/10h for program, 60h/D0h for erase, 70h for status and FFh for reset.
- R3: Read and program take five address bytes in this order: column low, column high, then three row bytes. Erase takes three row bytes. The column wraps modulo PAGE_BYTES (data plus spare). The row is the low log2(BLOCKS*PAGES) bits of the first row byte, with row = block*PAGES + page.
- R4: The sequence 00h, address, 30h holds `rb_n` low for exactly T_READ cycles and then copies the page into the page register. Each low phase of `re_n` shows the byte at the current column. Each rise of `re_n` moves to the next column, and the column wraps from the last spare byte to 0.
- R5: 80h fills the page register with FFh. Data bytes then load it from the addressed column upward. 10h holds `rb_n` low for exactly T_PROG cycles, and each stored byte becomes the old byte AND the page register byte.
- R6: The sequence 60h, rows, D0h holds `rb_n` low for exactly T_ERASE cycles and then sets every byte of every page in the addressed block to FFh. The page bits of the row are ignored.
- R7: Spare columns DATA_BYTES..PAGE_BYTES-1 are programmed and read exactly like data columns.
- R8: After 70h, the output is the status byte until the next 00h, 80h, 60h or FFh. Bit 6 is 1 when ready, bit 0 is 1 if the last program or erase failed, and all other bits are 0. The status byte can be read while busy.
- R9: A program or erase aimed at a block whose bit is set in BAD_MASK leaves the array unchanged and sets the fail bit when it ends.
- R10: While busy, every command except 70h and FFh is ignored, and so are all address and data cycles.
- R11: FFh aborts a running operation, leaving the array untouched, and `rb_n` is high on the next cycle. It also clears the fail bit and status mode.
- R12: `dq_oe` is 1 only while `ce_n` and `re_n` are both low, and `dq_out` is 00h whenever `dq_oe` is 0.
- R13: After `rst_n`, `rb_n` is high and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulator clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latches on rise |
| re_n | input | 1 | Read strobe, output enabled while low |
| dq_in | input | 8 | Bus bytes from host |
| dq_out | output | 8 | Bus bytes to host |
| dq_oe | output | 1 | Output enable; low stands for a released bus |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
The checker watches, on every cycle, that the bus stays released in standby, that the column pointer never leaves the page, and that busy goes low right after an operation starts and never outlasts the longest operation time. It also checks that an operation ending on a bad block raises the fail bit, and that the output byte holds steady during a read-strobe low phase. The effects on the array can only be seen in the bench's scenarios. These are AND-only programming, whole-block erase, column and row wrap, an abort that leaves data intact, commands ignored while busy, and strobes ignored in standby, each shown by reading the array back through the bus.

// File: rtl/nand_emu_pkg.sv
package nand_emu_pkg;
  localparam logic [7:0] CMD_RD_SETUP = 8'h00;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_PG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PG_GO    = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RESET    = 8'hFF;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_PROG, PH_ERASE} phase_t;
  typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_PROG, OP_ERASE} op_t;
endpackage

// File: rtl/nand_pin_if.sv
module nand_pin_if (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  output logic cmd_stb,
  output logic addr_stb,
  output logic data_stb,
  output logic rd_adv,
  output logic rd_en
);
  logic we_q, re_q, we_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  always_comb begin
    we_rise  = we_n & ~we_q & ~ce_n;
    cmd_stb  = we_rise & cle & ~ale;
    addr_stb = we_rise & ale & ~cle;
    data_stb = we_rise & ~cle & ~ale;
    rd_adv   = re_n & ~re_q & ~ce_n;
    rd_en    = ~ce_n & ~re_n;
  end
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] len,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= len - CW'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign done = busy & (cnt == '0) & ~abort;
endmodule

// File: rtl/nand_array.sv
module nand_array #(
  parameter int ROWS   = 16,
  parameter int PB     = 18,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 5,
  parameter int PAGES  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pr_fill,
  input  logic             pr_wr,
  input  logic [COL_W-1:0] pr_col,
  input  logic [7:0]       pr_wdata,
  output logic [7:0]       pr_rdata,
  input  logic             op_load,
  input  logic             op_prog,
  input  logic             op_erase,
  input  logic [ROW_W-1:0] row
);
  logic [7:0] mem  [ROWS][PB];
  logic [7:0] preg [PB];
  logic [ROW_W-1:0] blk_base;

  assign blk_base = row & ~ROW_W'(PAGES - 1);
  assign pr_rdata = preg[pr_col];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < PB; c++) mem[r][c] <= 8'hFF;
      for (int c = 0; c < PB; c++) preg[c] <= 8'hFF;
    end else begin
      if (op_load) begin
        for (int c = 0; c < PB; c++) preg[c] <= mem[row][c];
      end else if (pr_fill) begin
        for (int c = 0; c < PB; c++) preg[c] <= 8'hFF;
      end else if (pr_wr) begin
        preg[pr_col] <= pr_wdata;
      end
      if (op_prog) begin
        for (int c = 0; c < PB; c++) mem[row][c] <= mem[row][c] & preg[c];
      end
      if (op_erase) begin
        for (int p = 0; p < PAGES; p++)
          for (int c = 0; c < PB; c++) mem[blk_base | ROW_W'(p)][c] <= 8'hFF;
      end
    end
  end
endmodule

// File: rtl/nand_emu.sv
module nand_emu
  import nand_emu_pkg::*;
#(
  parameter int BLOCKS      = 4,
  parameter int PAGES       = 4,
  parameter int DATA_BYTES  = 16,
  parameter int SPARE_BYTES = 2,
  parameter int T_READ      = 6,
  parameter int T_PROG      = 16,
  parameter int T_ERASE     = 64,
  parameter logic [BLOCKS-1:0] BAD_MASK = 4'b0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic [7:0] dq_in,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic       rb_n
);
  localparam int PB     = DATA_BYTES + SPARE_BYTES;
  localparam int ROWS   = BLOCKS * PAGES;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(PB);
  localparam int PAGE_W = $clog2(PAGES);
  localparam int T_MAX  = (T_ERASE > T_PROG) ? ((T_ERASE > T_READ) ? T_ERASE : T_READ)
                                             : ((T_PROG > T_READ) ? T_PROG : T_READ);
  localparam int CW     = $clog2(T_MAX + 1);

  logic cmd_stb, addr_stb, data_stb, rd_adv, rd_en;
  logic busy, t_done, t_start, t_abort;
  logic [CW-1:0] t_len;
  phase_t phase;
  op_t op_q, op_n;
  logic [2:0] acnt;
  logic [7:0] col_lo;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col, col_inc, col_wrap;
  logic [15:0] col_full;
  logic fail, stat_mode, bad, wr_end;
  logic pr_fill, pr_wr;
  logic [7:0] pr_rdata, status;

  nand_pin_if u_pins (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .cmd_stb(cmd_stb), .addr_stb(addr_stb), .data_stb(data_stb), .rd_adv(rd_adv), .rd_en(rd_en)
  );

  nand_busy_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(t_start), .abort(t_abort), .len(t_len),
    .busy(busy), .done(t_done)
  );

  assign bad    = BAD_MASK[row_q[ROW_W-1:PAGE_W]];
  assign wr_end = t_done & ((op_q == OP_PROG) | (op_q == OP_ERASE));

  nand_array #(.ROWS(ROWS), .PB(PB), .ROW_W(ROW_W), .COL_W(COL_W), .PAGES(PAGES)) u_array (
    .clk(clk), .rst_n(rst_n), .pr_fill(pr_fill), .pr_wr(pr_wr), .pr_col(col),
    .pr_wdata(dq_in), .pr_rdata(pr_rdata),
    .op_load(t_done & (op_q == OP_LOAD)),
    .op_prog(t_done & (op_q == OP_PROG) & ~bad),
    .op_erase(t_done & (op_q == OP_ERASE) & ~bad),
    .row(row_q)
  );

  always_comb begin
    col_full = (acnt == 3'd1) ? {dq_in, col_lo} : {8'h00, dq_in};
    col_wrap = COL_W'(32'(col_full) % PB);
    col_inc  = (col == COL_W'(PB - 1)) ? '0 : col + COL_W'(1);
    t_start  = 1'b0;
    t_abort  = 1'b0;
    t_len    = '0;
    op_n     = op_q;
    if (cmd_stb && busy) begin
      t_abort = (dq_in == CMD_RESET);
    end else if (cmd_stb) begin
      if (dq_in == CMD_RD_GO && phase == PH_READ && acnt == 3'd5) begin
        t_start = 1'b1; t_len = CW'(T_READ); op_n = OP_LOAD;
      end else if (dq_in == CMD_PG_GO && phase == PH_PROG && acnt == 3'd5) begin
        t_start = 1'b1; t_len = CW'(T_PROG); op_n = OP_PROG;
      end else if (dq_in == CMD_ER_GO && phase == PH_ERASE && acnt == 3'd3) begin
        t_start = 1'b1; t_len = CW'(T_ERASE); op_n = OP_ERASE;
      end
    end
    pr_fill = cmd_stb & ~busy & (dq_in == CMD_PG_SETUP);
    pr_wr   = data_stb & ~busy & (phase == PH_PROG) & (acnt == 3'd5);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      op_q      <= OP_NONE;
      acnt      <= '0;
      col_lo    <= '0;
      row_q     <= '0;
      col       <= '0;
      fail      <= 1'b0;
      stat_mode <= 1'b0;
    end else begin
      if (t_start) op_q <= op_n;
      if (wr_end)  fail <= bad;
      if (cmd_stb) begin
        if (busy) begin
          if (dq_in == CMD_RESET) begin
            phase <= PH_IDLE; stat_mode <= 1'b0; fail <= 1'b0; col <= '0;
          end else if (dq_in == CMD_STATUS) begin
            stat_mode <= 1'b1;
          end
        end else begin
          case (dq_in)
            CMD_RD_SETUP: begin phase <= PH_READ;  acnt <= '0; stat_mode <= 1'b0; end
            CMD_PG_SETUP: begin phase <= PH_PROG;  acnt <= '0; stat_mode <= 1'b0; end
            CMD_ER_SETUP: begin phase <= PH_ERASE; acnt <= '0; stat_mode <= 1'b0; end
            CMD_STATUS:   stat_mode <= 1'b1;
            CMD_RESET: begin
              phase <= PH_IDLE; stat_mode <= 1'b0; fail <= 1'b0; col <= '0;
            end
            default:      phase <= PH_IDLE;
          endcase
        end
      end else if (addr_stb && !busy) begin
        if ((phase == PH_READ || phase == PH_PROG) && acnt < 3'd5) begin
          acnt <= acnt + 3'd1;
          case (acnt)
            3'd0:    begin col_lo <= dq_in; col <= col_wrap; end
            3'd1:    col <= col_wrap;
            3'd2:    row_q <= dq_in[ROW_W-1:0];
            default: ;
          endcase
        end else if (phase == PH_ERASE && acnt < 3'd3) begin
          acnt <= acnt + 3'd1;
          if (acnt == 3'd0) row_q <= dq_in[ROW_W-1:0];
        end
      end else if (pr_wr) begin
        col <= col_inc;
      end else if (rd_adv && !stat_mode && !busy) begin
        col <= col_inc;
      end
    end
  end

  assign status = {1'b0, ~busy, 5'b00000, fail};
  assign dq_out = rd_en ? (stat_mode ? status : pr_rdata) : 8'h00;
  assign dq_oe  = rd_en;
  assign rb_n   = ~busy;
endmodule

// File: rtl/nand_emu_chk.sv
module nand_emu_chk #(
  parameter int T_MAX = 64,
  parameter int PB    = 18,
  parameter int COL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             re_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic [7:0]       dq_out,
  input logic             rb_n,
  input logic             t_start,
  input logic [COL_W-1:0] col,
  input logic             wr_end,
  input logic             bad,
  input logic             fail
);
  logic [31:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     bcnt <= '0;
    else if (!rb_n) bcnt <= bcnt + 32'd1;
    else            bcnt <= '0;
  end

  // R1: standby keeps the bus released
  p_hiz_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe);

  // R3: column pointer stays within the page
  p_col_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(col) < PB);

  // R4: starting an operation drops ready/busy on the next cycle
  p_busy_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    t_start |=> !rb_n);

  // R6: no busy period outlasts the longest operation
  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_n |-> (bcnt < 32'(T_MAX)));

  // R9: an operation ending on a bad block reports failure
  p_fail_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && bad) |=> fail);

  // R12: output byte holds steady through a read-strobe low phase
  p_dq_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !re_n && $past(!ce_n && !re_n) && rb_n && $past(rb_n) && $stable(we_n))
      |-> $stable(dq_out));
endmodule

bind nand_emu nand_emu_chk #(.T_MAX(T_MAX), .PB(PB), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .re_n(re_n), .we_n(we_n), .dq_oe(dq_oe),
  .dq_out(dq_out), .rb_n(rb_n), .t_start(t_start), .col(col), .wr_end(wr_end),
  .bad(bad), .fail(fail)
);

// File: tb/test_nand_emu.sv
module test_nand_emu;
  localparam int CLK_PERIOD = 10;
  localparam int T_READ  = 6;
  localparam int T_PROG  = 16;
  localparam int T_ERASE = 64;

  // {row, col, write byte, expected readback, expected fail}
  localparam logic [32:0] VECS [6] = '{
    {8'h01, 8'h00, 8'hA5, 8'hA5, 1'b0},
    {8'h01, 8'h00, 8'h3C, 8'h24, 1'b0},
    {8'h06, 8'h11, 8'h0F, 8'h0F, 1'b0},
    {8'h16, 8'h23, 8'hF0, 8'h00, 1'b0},
    {8'h0F, 8'h10, 8'h81, 8'h81, 1'b0},
    {8'h09, 8'h02, 8'h00, 8'hFF, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, ce_n, cle, ale, we_n, re_n, dq_oe, rb_n;
  logic [7:0] dq_in, dq_out;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_emu i_nand_emu (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .rb_n(rb_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; dq_in = b; we_n = 1'b0;
    @(negedge clk); @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);  bus_write(1'b1, 1'b0, b); endtask
  task automatic addr(input logic [7:0] b); bus_write(1'b0, 1'b1, b); endtask
  task automatic data(input logic [7:0] b); bus_write(1'b0, 1'b0, b); endtask

  task automatic addr5(input logic [15:0] c, input logic [23:0] r);
    addr(c[7:0]); addr(c[15:8]); addr(r[7:0]); addr(r[15:8]); addr(r[23:16]);
  endtask

  task automatic cmd_timed(input logic [7:0] b, output int n);
    @(negedge clk); cle = 1'b1; dq_in = b; we_n = 1'b0;
    @(negedge clk); @(negedge clk); we_n = 1'b1;
    n = 0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (rb_n) break;
      n++;
    end
    cle = 1'b0;
  endtask

  task automatic wait_ready();
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (rb_n) break;
    end
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); @(negedge clk); b = dq_out;
    re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_at(input logic [7:0] r, input logic [7:0] c, output logic [7:0] b, output int n);
    cmd(8'h00); addr5({8'h00, c}, {16'h0000, r}); cmd_timed(8'h30, n); rd_byte(b);
  endtask

  task automatic prog_at(input logic [7:0] r, input logic [7:0] c, input logic [7:0] d, output int n);
    cmd(8'h80); addr5({8'h00, c}, {16'h0000, r}); data(d); cmd_timed(8'h10, n);
  endtask

  task automatic status(output logic [7:0] b);
    cmd(8'h70); rd_byte(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int n;
    rst_n = 1'b0; ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we_n = 1'b1; re_n = 1'b1; dq_in = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; ce_n = 1'b0;
    @(negedge clk);
    check("R13 ready after reset", 32'(rb_n), 32'd1);
    check("R12 released bus after reset", 32'(dq_oe), 32'd0);
    check("R12 idle output byte", 32'(dq_out), 32'h00);

    read_at(8'h00, 8'h00, b, n);
    check("R13 erased array after reset", 32'(b), 32'hFF);
    check("R4 read busy length", 32'(n), 32'(T_READ));

    // table: R5 AND-programming, R7 spare columns, R3 wrap, R9 bad block
    for (int i = 0; i < 6; i++) begin
      prog_at(VECS[i][32:25], VECS[i][24:17], VECS[i][16:9], n);
      check($sformatf("R5 program busy length entry %0d", i), 32'(n), 32'(T_PROG));
      status(b);
      check($sformatf("R9 status after program entry %0d", i), 32'(b),
            32'(VECS[i][0] ? 8'h41 : 8'h40));
      read_at(VECS[i][32:25], VECS[i][24:17], b, n);
      check($sformatf("R5 R7 R3 readback entry %0d", i), 32'(b), 32'(VECS[i][8:1]));
    end

    // R11: abort an erase of block 3
    cmd(8'h60); addr(8'h0C); addr(8'h00); addr(8'h00); cmd(8'hD0);
    check("R11 busy after erase start", 32'(rb_n), 32'd0);
    cmd(8'hFF);
    check("R11 ready right after abort", 32'(rb_n), 32'd1);
    status(b);
    check("R11 fail cleared by reset command", 32'(b), 32'h40);
    read_at(8'h0F, 8'h10, b, n);
    check("R11 aborted erase left data", 32'(b), 32'h81);

    // R8 status while busy, R10 commands ignored while busy
    cmd(8'h60); addr(8'h0D); addr(8'h00); addr(8'h00); cmd(8'hD0);
    status(b);
    check("R8 status while busy", 32'(b), 32'h00);
    cmd(8'h60); addr(8'h00); addr(8'h00); addr(8'h00); cmd(8'hD0);
    wait_ready();
    rd_byte(b);
    check("R8 status after erase", 32'(b), 32'h40);
    read_at(8'h01, 8'h00, b, n);
    check("R10 block 0 untouched by ignored erase", 32'(b), 32'h24);
    read_at(8'h0F, 8'h10, b, n);
    check("R6 block 3 erased", 32'(b), 32'hFF);

    // R6 timed erase of block 0 through a row with nonzero page bits
    cmd(8'h60); addr(8'h02); addr(8'h00); addr(8'h00); cmd_timed(8'hD0, n);
    check("R6 erase busy length", 32'(n), 32'(T_ERASE));
    read_at(8'h01, 8'h00, b, n);
    check("R6 other page of block erased", 32'(b), 32'hFF);

    // R4 streaming with column wrap, R2 data cycles
    cmd(8'h80); addr5(16'h0000, 24'h000005); data(8'h11); data(8'h22); data(8'h33);
    cmd_timed(8'h10, n);
    cmd(8'h00); addr5(16'h0010, 24'h000005); cmd_timed(8'h30, n);
    rd_byte(b); check("R4 stream col 16", 32'(b), 32'hFF);
    rd_byte(b); check("R4 stream col 17", 32'(b), 32'hFF);
    rd_byte(b); check("R4 stream wrap col 0", 32'(b), 32'h11);
    rd_byte(b); check("R2 R4 stream col 1", 32'(b), 32'h22);
    rd_byte(b); check("R4 stream col 2", 32'(b), 32'h33);

    // R5 page register filled with FFh by 80h
    prog_at(8'h07, 8'h03, 8'h7E, n);
    read_at(8'h07, 8'h00, b, n);
    check("R5 unloaded byte stays erased", 32'(b), 32'hFF);
    read_at(8'h07, 8'h03, b, n);
    check("R5 loaded byte stored", 32'(b), 32'h7E);

    // R1 standby ignores strobes
    ce_n = 1'b1;
    prog_at(8'h04, 8'h00, 8'h00, n);
    check("R1 no busy in standby", 32'(n), 32'd0);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 bus released in standby", 32'(dq_oe), 32'd0);
    re_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    read_at(8'h04, 8'h00, b, n);
    check("R1 standby program had no effect", 32'(b), 32'hFF);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R12 bus driven while selected and reading", 32'(dq_oe), 32'd1);
    re_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule